// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a logical address, made of a segment register and a 32-bit offset, onto a 32-bit physical address. It holds four segment registers: code, stack, and two data registers. Each one has a visible 16-bit value and a hidden cache of base, effective limit and rights. A protection-enable input picks how a load fills that cache. With protection off, the 16-bit value itself yields a base of value times sixteen and a fixed 64 KiB readable/writable segment. With protection on, the value is a selector, and the caller supplies the 64-bit descriptor that the selector points at. The block unpacks the base, limit and rights from that descriptor and checks whether it is legal for the target register.

The caller does all translations through the hidden cache, whatever the protection input is doing at the time. Changing the mode therefore has no effect on a segment until that segment is loaded again. Each translate request returns exactly one response on the next cycle: a physical address with an ok pulse, or a fault pulse when the offset lies beyond the cached limit. Each response also returns the segment's selector and rights, so that downstream exception logic can report them. A rejected load leaves the register and its cache untouched and pulses a load-fault output on the next cycle.

Register select encoding: 0 = code, 1 = stack, 2 = data A, 3 = data B.

Top module: `seg_xlate`

## Requirements
- R1: After reset, every register holds value 0, base 0, limit 0xFFFF and rights 0x093, and all outputs are low.
- R2: With prot_en low, a load of any 16-bit value into any register is accepted and the descriptor input is ignored. The cache becomes base = value << 4, limit 0xFFFF, rights 0x093, and the selector becomes the value.
- R3: A request with xl_valid high gives, on the next cycle, exactly one of xl_ok or xl_fault. When it is ok, xl_addr = cached base + offset, modulo 2^32. With no request, both outputs stay low on the next cycle.
- R4: The limit is inclusive: an offset equal to the effective limit is accepted, and an offset one above it faults.
- R5: If a descriptor has bit 55 (granularity) set, the effective limit is {limit[19:0], 12'hFFF}. Otherwise it is the 20-bit limit, zero-extended.
- R6: A protected load takes base[15:0] from descriptor bits 31:16, base[23:16] from bits 39:32, base[31:24] from bits 63:56, and limit[15:0]/[19:16] from bits 15:0/51:48. The rights become {desc[55:52], desc[47:40]}, and the selector becomes the value.
- R7: A protected load of a descriptor with bit 47 (present) clear pulses ld_fault on the next cycle and leaves the cache and selector unchanged.
- R8: A protected load into the code register of a descriptor with bit 43 (executable) clear is rejected like R7.
- R9: A protected load into the stack register of a descriptor with bit 43 set is rejected like R7.
- R10: A change of prot_en, or a cycle with no load, leaves every cache entry as it was. Translations keep using the cached values.
- R11: On a limit fault, xl_ok stays low and xl_addr is zero. xl_selector and xl_rights still report the segment.
- R12: ld_fault is high only on the cycle after a rejected load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prot_en | input | 1 | Protection enable; chooses how loads fill the cache |
| ld_valid | input | 1 | Load strobe |
| ld_sel | input | 2 | Register to load |
| ld_value | input | 16 | Segment value or selector |
| ld_desc | input | 64 | Descriptor indexed by the selector (protected loads only) |
| ld_fault | output | 1 | Pulse: previous load rejected |
| xl_valid | input | 1 | Translate request |
| xl_sel | input | 2 | Register used for translation |
| xl_offset | input | 32 | Offset within the segment |
| xl_ok | output | 1 | Pulse: translation succeeded |
| xl_fault | output | 1 | Pulse: offset beyond limit |
| xl_addr | output | 32 | Physical address (zero unless ok) |
| xl_selector | output | 16 | Selector of the translated segment |
| xl_rights | output | 12 | Cached rights of the translated segment |

## Verification
The assertions check on every cycle that each request gets exactly one response and that no response appears without a request. They also check that load faults only follow load strobes, that absent, non-executable-code and executable-stack descriptors always raise a fault, that a fault or an idle cycle leaves the cache unchanged, and that a faulting translation returns address zero. The bench scenarios are needed for the arithmetic: real-mode base scaling, unpacking of the scattered descriptor fields, granular limits with their inclusive boundaries, address wraparound, and the fact that cached segments survive mode switches in both directions.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int NSEG   = 4,
  parameter int CS_IDX = 0,
  parameter int SS_IDX = 1,
  localparam int SW    = $clog2(NSEG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_en,
  input  logic          ld_valid,
  input  logic [SW-1:0] ld_sel,
  input  logic [15:0]   ld_value,
  input  logic [63:0]   ld_desc,
  output logic          ld_fault,
  input  logic          xl_valid,
  input  logic [SW-1:0] xl_sel,
  input  logic [31:0]   xl_offset,
  output logic          xl_ok,
  output logic          xl_fault,
  output logic [31:0]   xl_addr,
  output logic [15:0]   xl_selector,
  output logic [11:0]   xl_rights
);

  localparam logic [SW-1:0] CS_SEL = SW'(CS_IDX);
  localparam logic [SW-1:0] SS_SEL = SW'(SS_IDX);
  localparam logic [31:0]   RM_LIM = 32'h0000_FFFF;
  localparam logic [11:0]   RM_RTS = 12'h093;

  logic [NSEG-1:0][15:0] sel_q;
  logic [NSEG-1:0][31:0] base_q;
  logic [NSEG-1:0][31:0] lim_q;
  logic [NSEG-1:0][11:0] rts_q;

  wire [31:0] d_base = {ld_desc[63:56], ld_desc[39:32], ld_desc[31:16]};
  wire [19:0] d_lim  = {ld_desc[51:48], ld_desc[15:0]};
  wire        d_gran = ld_desc[55];
  wire        d_pres = ld_desc[47];
  wire        d_exec = ld_desc[43];
  wire [31:0] d_elim = d_gran ? {d_lim, 12'hFFF} : {12'h000, d_lim};

  wire bad = prot_en && (!d_pres ||
                         (ld_sel == CS_SEL && !d_exec) ||
                         (ld_sel == SS_SEL &&  d_exec));

  wire [31:0] n_base = prot_en ? d_base : {12'h000, ld_value, 4'h0};
  wire [31:0] n_lim  = prot_en ? d_elim : RM_LIM;
  wire [11:0] n_rts  = prot_en ? {ld_desc[55:52], ld_desc[47:40]} : RM_RTS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        sel_q[i]  <= '0;
        base_q[i] <= '0;
        lim_q[i]  <= RM_LIM;
        rts_q[i]  <= RM_RTS;
      end
      ld_fault <= 1'b0;
    end else begin
      ld_fault <= ld_valid && bad;
      if (ld_valid && !bad) begin
        sel_q[ld_sel]  <= ld_value;
        base_q[ld_sel] <= n_base;
        lim_q[ld_sel]  <= n_lim;
        rts_q[ld_sel]  <= n_rts;
      end
    end
  end

  wire over = xl_offset > lim_q[xl_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_ok       <= 1'b0;
      xl_fault    <= 1'b0;
      xl_addr     <= '0;
      xl_selector <= '0;
      xl_rights   <= '0;
    end else begin
      xl_ok       <= xl_valid && !over;
      xl_fault    <= xl_valid && over;
      xl_addr     <= (xl_valid && !over) ? base_q[xl_sel] + xl_offset : '0;
      xl_selector <= xl_valid ? sel_q[xl_sel] : '0;
      xl_rights   <= xl_valid ? rts_q[xl_sel] : '0;
    end
  end

  a_r3_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> (xl_ok != xl_fault));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |=> (!xl_ok && !xl_fault));
  a_r11_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    xl_fault |-> (xl_addr == 32'h0));
  a_r12_fault_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !ld_fault);
  a_r7_absent_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && prot_en && !ld_desc[47]) |=> ld_fault);
  a_r8_cs_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && prot_en && ld_sel == CS_SEL && !ld_desc[43]) |=> ld_fault);
  a_r9_ss_rejects_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && prot_en && ld_sel == SS_SEL && ld_desc[43]) |=> ld_fault);
  a_r7_reject_keeps_cache: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> ($stable(base_q) && $stable(lim_q) && $stable(sel_q)));
  a_r10_idle_keeps_cache: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> ($stable(base_q) && $stable(lim_q) && $stable(rts_q) && $stable(sel_q)));

endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
  logic        clk = 0, rst_n = 0, prot_en = 0;
  logic        ld_valid = 0, xl_valid = 0;
  logic [1:0]  ld_sel = 0, xl_sel = 0;
  logic [15:0] ld_value = 0;
  logic [63:0] ld_desc = 0;
  logic [31:0] xl_offset = 0;
  logic        ld_fault, xl_ok, xl_fault;
  logic [31:0] xl_addr;
  logic [15:0] xl_selector;
  logic [11:0] xl_rights;

  always #2 clk = ~clk;

  seg_xlate dut_i (.clk(clk), .rst_n(rst_n), .prot_en(prot_en),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_value(ld_value), .ld_desc(ld_desc),
    .ld_fault(ld_fault), .xl_valid(xl_valid), .xl_sel(xl_sel), .xl_offset(xl_offset),
    .xl_ok(xl_ok), .xl_fault(xl_fault), .xl_addr(xl_addr),
    .xl_selector(xl_selector), .xl_rights(xl_rights));

  typedef struct {
    bit          ok;
    logic [31:0] addr;
    logic [15:0] sel;
    logic [11:0] rts;
    string       tag;
  } xexp_t;
  typedef struct {
    bit    flt;
    string tag;
  } lexp_t;

  xexp_t xq[$];
  lexp_t lq[$];
  int checks = 0, fails = 0;

  logic [31:0] m_base [4];
  logic [31:0] m_lim  [4];
  logic [15:0] m_sel  [4];
  logic [11:0] m_rts  [4];

  task automatic chk(input bit good, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
                                           input bit g, input bit p, input bit x);
    logic [7:0] acc = {p, 2'b00, 1'b1, x, 1'b0, 1'b1, 1'b0};
    return {b[31:24], g, 1'b1, 2'b00, l[19:16], acc, b[23:16], b[15:0], l[15:0]};
  endfunction

  task automatic load(input logic [1:0] s, input logic [15:0] v,
                      input logic [63:0] d, input string tag);
    bit bad;
    lexp_t e;
    @(negedge clk);
    ld_valid = 1; ld_sel = s; ld_value = v; ld_desc = d;
    bad = prot_en && (!d[47] || (s == 0 && !d[43]) || (s == 1 && d[43]));
    e.flt = bad; e.tag = tag;
    lq.push_back(e);
    if (!bad) begin
      m_sel[s] = v;
      if (prot_en) begin
        m_base[s] = {d[63:56], d[39:32], d[31:16]};
        m_lim[s]  = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'h0, d[51:48], d[15:0]};
        m_rts[s]  = {d[55:52], d[47:40]};
      end else begin
        m_base[s] = {12'h0, v, 4'h0};
        m_lim[s]  = 32'hFFFF;
        m_rts[s]  = 12'h093;
      end
    end
    @(negedge clk);
    ld_valid = 0;
  endtask

  task automatic xlate(input logic [1:0] s, input logic [31:0] off, input string tag);
    xexp_t e;
    @(negedge clk);
    xl_valid = 1; xl_sel = s; xl_offset = off;
    e.ok   = (off <= m_lim[s]);
    e.addr = e.ok ? m_base[s] + off : 32'h0;
    e.sel  = m_sel[s];
    e.rts  = m_rts[s];
    e.tag  = tag;
    xq.push_back(e);
    @(negedge clk);
    xl_valid = 0;
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (xl_valid) begin
        xexp_t e;
        if (xq.size() == 0) chk(0, "R3", "unexpected request", 0, 0);
        else begin
          e = xq.pop_front();
          chk(xl_ok == e.ok && xl_fault == !e.ok, e.tag, "ok/fault",
              {xl_ok, xl_fault}, {e.ok, !e.ok});
          chk(xl_addr == e.addr, e.tag, "addr", xl_addr, e.addr);
          chk(xl_selector == e.sel && xl_rights == e.rts, e.tag, "sel/rights",
              {xl_selector, xl_rights}, {e.sel, e.rts});
        end
      end else if (xl_ok || xl_fault)
        chk(0, "R3", "response without request", {xl_ok, xl_fault}, 0);
      if (ld_valid) begin
        lexp_t e;
        if (lq.size() == 0) chk(0, "R12", "unexpected load", 0, 0);
        else begin
          e = lq.pop_front();
          chk(ld_fault == e.flt, e.tag, "ld_fault", ld_fault, e.flt);
        end
      end else if (ld_fault)
        chk(0, "R12", "ld_fault without load", 1, 0);
    end
  end

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      chk(0, "WATCHDOG", "timeout", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_lim[i] = 32'hFFFF; m_sel[i] = 0; m_rts[i] = 12'h093;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({ld_fault, xl_ok, xl_fault, xl_addr, xl_selector, xl_rights} == 0, "R1",
        "reset outputs", {ld_fault, xl_ok, xl_fault}, 0);
    xlate(2, 32'h1234, "R1_reset_cache");
    xlate(3, 32'h10000, "R1_reset_limit");

    load(2, 16'h1234, mk_desc(32'hDEAD0000, 20'h1, 0, 0, 1), "R2_real_load_ignores_desc");
    xlate(2, 32'h10, "R2_real_base");
    load(0, 16'hFFFF, 64'h0, "R2_real_cs_any_value");
    xlate(0, 32'hFFFF, "R4_real_at_limit");
    xlate(0, 32'h10000, "R11_real_over_limit");

    prot_en = 1;
    xlate(2, 32'h10, "R10_after_enable");
    load(2, 16'h0010, mk_desc(32'hA1B2C3D4, 20'h00FFF, 0, 1, 0), "R6_prot_load");
    xlate(2, 32'hFFF, "R6_R4_at_limit");
    xlate(2, 32'h1000, "R4_over_limit");
    load(3, 16'h0018, mk_desc(32'h00400000, 20'h00002, 1, 1, 0), "R5_gran_load");
    xlate(3, 32'h2FFF, "R5_gran_at_limit");
    xlate(3, 32'h3000, "R5_gran_over");
    load(1, 16'h0020, mk_desc(32'h00100000, 20'hFFFFF, 0, 0, 0), "R7_absent");
    xlate(1, 32'h20, "R7_cache_kept");
    load(0, 16'h0028, mk_desc(32'h00200000, 20'hFFFFF, 0, 1, 0), "R8_cs_data_rejected");
    xlate(0, 32'h0, "R8_cs_kept");
    load(0, 16'h0030, mk_desc(32'h00300000, 20'h0FFFF, 0, 1, 1), "R8_cs_exec_ok");
    xlate(0, 32'h44, "R8_cs_new_base");
    load(1, 16'h0038, mk_desc(32'h00500000, 20'hFFFFF, 0, 1, 1), "R9_ss_exec_rejected");
    xlate(1, 32'h8, "R9_ss_kept");
    load(1, 16'h0040, mk_desc(32'h00600000, 20'h0FFFF, 0, 1, 0), "R9_ss_data_ok");
    xlate(1, 32'h8, "R9_ss_new_base");
    load(2, 16'h0048, mk_desc(32'hFFFFF000, 20'hFFFFF, 1, 1, 0), "R3_wrap_load");
    xlate(2, 32'h2000, "R3_wrap_addr");

    prot_en = 0;
    xlate(2, 32'h2000, "R10_after_disable");
    xlate(0, 32'h44, "R10_cs_after_disable");
    load(3, 16'h0001, 64'h0, "R2_real_after_disable");
    xlate(3, 32'h5, "R2_real_base_small");

    repeat (3) @(negedge clk);
    chk(xq.size() == 0 && lq.size() == 0, "R3", "pending responses",
        xq.size() + lq.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule